// File: doc/BRIEF.md
# Real-Time Clock Second Timebase with Alarm and Drift Trim

This block turns a free-running 32.768 kHz enable strobe into a one-second timebase and keeps a time-of-day count of seconds, minutes and hours. On each second boundary it can raise a periodic tick event. The tick can come every second, or only when the seconds, the minutes or the hours have just rolled over to zero. A separate alarm countdown, loaded in seconds, raises an alarm event when it runs out. The alarm event is only raised while the alarm is enabled.

Crystal drift is trimmed once per correction interval. At each correction point the following second is made shorter or longer by a signed 16-bit count of enable periods. A positive count shortens it. The count is written one byte at a time. Both event outputs are single-cycle pulses that go to an interrupt controller. They appear in the same cycle as the updated time fields.

The enables per second, the three rollover counts, the correction spacing, the alarm reset value and the alarm width are all parameters. Shrinking them makes long spans observable in a short run.

Top module: `rtc_tick_core`

## Requirements
- R1: While `run_en` is high, a second boundary occurs on the enable that makes the count reach the current second length (PRESCALE enables when untrimmed). While `run_en` is low, enables are ignored and the partial count is held, and counting resumes from that point when it goes high again.
- R2: At each second boundary `secs` advances and wraps from SEC_WRAP-1 to 0, carrying into `mins` (wrap MIN_WRAP-1 to 0), which carries into `hours` (wrap HOUR_WRAP-1 to 0). Between boundaries the fields hold.
- R3: `period_sel` picks the tick event: 0 fires at every boundary, 1 only when `secs` wraps to 0, 2 only when `mins` and `secs` both wrap to 0, and 3 only when all three fields wrap to 0.
- R4: The alarm countdown decrements at every boundary while it is non-zero, whether or not the alarm is enabled. `evt_alarm` pulses on the boundary where it steps from 1 to 0, and only if `alarm_en` is high in that cycle.
- R5: `alarm_load` replaces the countdown with `alarm_secs` only when `run_en` and `alarm_en` are both high. Otherwise it is ignored, and the earlier countdown still ends on time.
- R6: After reset the time fields are 0, both events are low, the trim value is 0, the first correction point is CORR_FIRST boundaries away and the alarm countdown holds ALM_INIT.
- R7: On the boundary that completes CORR_FIRST seconds, and then every CORR_INTERVAL seconds, the next second lasts PRESCALE minus the trim value (two's complement) enables. All other seconds last PRESCALE enables.
- R8: A trimmed second length below 1 is clamped to 1 enable.
- R9: `comp_wr_hi` loads `comp_byte` into trim bits 15:8 and `comp_wr_lo` loads it into bits 7:0. Each write leaves the other half unchanged. A write takes effect for correction points in later cycles.
- R10: `evt_tick` and `evt_alarm` are one cycle wide, and each is coincident with the time-field update of its boundary. If `alarm_load` is accepted in a boundary cycle, the load takes precedence and no alarm is raised in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle strobe at the 32.768 kHz rate |
| run_en | input | 1 | Timebase run control |
| alarm_en | input | 1 | Alarm event enable |
| period_sel | input | 2 | Tick event period select |
| comp_wr_hi | input | 1 | Write `comp_byte` to the trim high byte |
| comp_wr_lo | input | 1 | Write `comp_byte` to the trim low byte |
| comp_byte | input | 8 | Trim byte data |
| alarm_load | input | 1 | Load the alarm countdown |
| alarm_secs | input | ALM_W | Alarm countdown value in seconds |
| evt_tick | output | 1 | Periodic tick event pulse |
| evt_alarm | output | 1 | Alarm event pulse |
| secs | output | $clog2(SEC_WRAP) | Seconds field |
| mins | output | $clog2(MIN_WRAP) | Minutes field |
| hours | output | $clog2(HOUR_WRAP) | Hours field |

## Verification
The tick event and the alarm event can fire on the same second boundary. An alarm load can also land in the very cycle of a boundary. The bench provokes the first case directly: it sets the every-second period and loads a short countdown, then requires both pulses in one cycle together with the matching seconds value. The load-versus-boundary collision is reached by random loads issued while enables arrive on most cycles. A cycle-level reference model built from the requirements judges every event, the time fields and the lengths of the trimmed seconds.

// File: rtl/rtc_tick_pkg.sv
// Shared types for the real-time clock timebase.
package rtc_tick_pkg;
    typedef enum logic [1:0] {
        TICK_EACH_SEC  = 2'd0,
        TICK_SEC_WRAP  = 2'd1,
        TICK_MIN_WRAP  = 2'd2,
        TICK_HOUR_WRAP = 2'd3
    } tick_period_e;
endpackage

// File: rtl/rtc_prescaler.sv
// Second prescaler: counts enable strobes down to a second boundary.
// Assumes reload_len is never zero and is valid in the boundary cycle.
module rtc_prescaler #(
    parameter int PRESCALE = 32768,
    parameter int PW       = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          run_en,
    input  logic [PW-1:0] reload_len,
    output logic          sec_strobe
);
    logic [PW-1:0] pre_cnt;

    // Boundary when the last enable of the current second arrives.
    always_comb sec_strobe = tick_en && run_en && (pre_cnt == PW'(1));

    // Count enables down, reload with the next second's length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_cnt <= PW'(PRESCALE);
        else if (tick_en && run_en)
            pre_cnt <= (pre_cnt == PW'(1)) ? reload_len : pre_cnt - PW'(1);
    end

    AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(pre_cnt)); // R1
endmodule

// File: rtl/rtc_drift_comp.sv
// Drift trim: holds the signed trim word and the correction countdown,
// and supplies the length of the next second to the prescaler.
// Assumes PW > 16 so the trimmed length never overflows.
module rtc_drift_comp #(
    parameter int PRESCALE      = 32768,
    parameter int CORR_FIRST    = 1800,
    parameter int CORR_INTERVAL = 3600,
    parameter int PW            = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_strobe,
    input  logic          comp_wr_hi,
    input  logic          comp_wr_lo,
    input  logic [7:0]    comp_byte,
    output logic [PW-1:0] reload_len
);
    localparam int CMAX = (CORR_FIRST > CORR_INTERVAL) ? CORR_FIRST : CORR_INTERVAL;
    localparam int CW   = $clog2(CMAX + 1);
    localparam int TW   = PW + 1;

    logic [15:0]          comp_q;
    logic [CW-1:0]        corr_cnt;
    logic                 corr_due;
    logic signed [TW-1:0] trimmed;

    // Length of the next second: trimmed at a correction point, clamped to 1.
    always_comb begin
        corr_due = (corr_cnt == CW'(1));
        trimmed  = $signed(TW'(PRESCALE)) - $signed({{(TW-16){comp_q[15]}}, comp_q});
        if (!corr_due)
            reload_len = PW'(PRESCALE);
        else if (trimmed[TW-1] || (trimmed == '0))
            reload_len = PW'(1);
        else
            reload_len = trimmed[PW-1:0];
    end

    // Byte-wise trim word updates, each half on its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            comp_q <= '0;
        end else begin
            if (comp_wr_hi) comp_q[15:8] <= comp_byte;
            if (comp_wr_lo) comp_q[7:0]  <= comp_byte;
        end
    end

    // Correction countdown in seconds, restarted at each correction point.
    always_ff @(posedge clk) begin
        if (!rst_n)
            corr_cnt <= CW'(CORR_FIRST);
        else if (sec_strobe)
            corr_cnt <= corr_due ? CW'(CORR_INTERVAL) : corr_cnt - CW'(1);
    end

    AST_HI_WRITE_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_wr_hi && !comp_wr_lo) |=> comp_q[7:0] == $past(comp_q[7:0])); // R9
    AST_LO_WRITE_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_wr_lo && !comp_wr_hi) |=> comp_q[15:8] == $past(comp_q[15:8])); // R9
endmodule

// File: rtl/rtc_time_count.sv
// Time-of-day counter: seconds, minutes, hours with parameterised wraps.
// Advances only on sec_strobe; exposes the wrap conditions of the
// current value so the event logic can act on the same boundary.
module rtc_time_count #(
    parameter int SEC_WRAP  = 60,
    parameter int MIN_WRAP  = 60,
    parameter int HOUR_WRAP = 24,
    parameter int SB        = 6,
    parameter int MB        = 6,
    parameter int HB        = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_strobe,
    output logic [SB-1:0] secs,
    output logic [MB-1:0] mins,
    output logic [HB-1:0] hours,
    output logic          sec_wrap,
    output logic          min_wrap,
    output logic          hour_wrap
);
    // Carry chain: which fields roll over at the next boundary.
    always_comb begin
        sec_wrap  = (secs == SB'(SEC_WRAP - 1));
        min_wrap  = sec_wrap && (mins == MB'(MIN_WRAP - 1));
        hour_wrap = min_wrap && (hours == HB'(HOUR_WRAP - 1));
    end

    // Advance the three fields on a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            secs  <= '0;
            mins  <= '0;
            hours <= '0;
        end else if (sec_strobe) begin
            secs <= sec_wrap ? '0 : secs + SB'(1);
            if (sec_wrap)  mins  <= min_wrap  ? '0 : mins + MB'(1);
            if (min_wrap)  hours <= hour_wrap ? '0 : hours + HB'(1);
        end
    end

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_strobe && !sec_wrap) |=> secs == $past(secs) + SB'(1)); // R2
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_strobe |=> $stable({hours, mins, secs})); // R2
endmodule

// File: rtl/rtc_events.sv
// Event logic: periodic tick selection and the alarm countdown.
// Both events are registered so they line up with the time update.
module rtc_events
    import rtc_tick_pkg::*;
#(
    parameter int ALM_W    = 17,
    parameter int ALM_INIT = 1800
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_strobe,
    input  logic             run_en,
    input  logic             alarm_en,
    input  logic [1:0]       period_sel,
    input  logic             sec_wrap,
    input  logic             min_wrap,
    input  logic             hour_wrap,
    input  logic             alarm_load,
    input  logic [ALM_W-1:0] alarm_secs,
    output logic             evt_tick,
    output logic             evt_alarm
);
    logic [ALM_W-1:0] alm_cnt;
    logic             tick_hit;
    logic             load_ok;

    // Select the rollover condition that qualifies a tick.
    always_comb begin
        load_ok = alarm_load && run_en && alarm_en;
        case (tick_period_e'(period_sel))
            TICK_EACH_SEC:  tick_hit = 1'b1;
            TICK_SEC_WRAP:  tick_hit = sec_wrap;
            TICK_MIN_WRAP:  tick_hit = min_wrap;
            default:        tick_hit = hour_wrap;
        endcase
    end

    // Register the events and run the alarm countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_tick  <= 1'b0;
            evt_alarm <= 1'b0;
            alm_cnt   <= ALM_W'(ALM_INIT);
        end else begin
            evt_tick  <= sec_strobe && tick_hit;
            evt_alarm <= sec_strobe && alarm_en && !load_ok && (alm_cnt == ALM_W'(1));
            if (load_ok)
                alm_cnt <= alarm_secs;
            else if (sec_strobe && (alm_cnt != '0))
                alm_cnt <= alm_cnt - ALM_W'(1);
        end
    end

    AST_TICK_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        evt_tick |-> $past(sec_strobe)); // R10
    AST_ALARM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        evt_alarm |-> $past(alarm_en)); // R4
    AST_ALARM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_alarm |=> !evt_alarm); // R10
    AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_load && !(run_en && alarm_en) && !sec_strobe) |=> $stable(alm_cnt)); // R5
endmodule

// File: rtl/rtc_tick_core.sv
// Real-time clock second timebase with tick/alarm events and drift trim.
// Assumes tick_en is a one-cycle strobe; all controls are synchronous.
module rtc_tick_core #(
    parameter int PRESCALE      = 32768,
    parameter int SEC_WRAP      = 60,
    parameter int MIN_WRAP      = 60,
    parameter int HOUR_WRAP     = 24,
    parameter int CORR_FIRST    = 1800,
    parameter int CORR_INTERVAL = 3600,
    parameter int ALM_W         = 17,
    parameter int ALM_INIT      = 1800,
    localparam int SB           = $clog2(SEC_WRAP),
    localparam int MB           = $clog2(MIN_WRAP),
    localparam int HB           = $clog2(HOUR_WRAP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             run_en,
    input  logic             alarm_en,
    input  logic [1:0]       period_sel,
    input  logic             comp_wr_hi,
    input  logic             comp_wr_lo,
    input  logic [7:0]       comp_byte,
    input  logic             alarm_load,
    input  logic [ALM_W-1:0] alarm_secs,
    output logic             evt_tick,
    output logic             evt_alarm,
    output logic [SB-1:0]    secs,
    output logic [MB-1:0]    mins,
    output logic [HB-1:0]    hours
);
    localparam int PW = $clog2(PRESCALE + 32768) + 1;

    logic          sec_strobe;
    logic [PW-1:0] reload_len;
    logic          sec_wrap, min_wrap, hour_wrap;

    rtc_drift_comp #(
        .PRESCALE(PRESCALE), .CORR_FIRST(CORR_FIRST),
        .CORR_INTERVAL(CORR_INTERVAL), .PW(PW)
    ) u_trim (
        .clk(clk), .rst_n(rst_n), .sec_strobe(sec_strobe),
        .comp_wr_hi(comp_wr_hi), .comp_wr_lo(comp_wr_lo),
        .comp_byte(comp_byte), .reload_len(reload_len)
    );

    rtc_prescaler #(.PRESCALE(PRESCALE), .PW(PW)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run_en(run_en),
        .reload_len(reload_len), .sec_strobe(sec_strobe)
    );

    rtc_time_count #(
        .SEC_WRAP(SEC_WRAP), .MIN_WRAP(MIN_WRAP), .HOUR_WRAP(HOUR_WRAP),
        .SB(SB), .MB(MB), .HB(HB)
    ) u_time (
        .clk(clk), .rst_n(rst_n), .sec_strobe(sec_strobe),
        .secs(secs), .mins(mins), .hours(hours),
        .sec_wrap(sec_wrap), .min_wrap(min_wrap), .hour_wrap(hour_wrap)
    );

    rtc_events #(.ALM_W(ALM_W), .ALM_INIT(ALM_INIT)) u_evt (
        .clk(clk), .rst_n(rst_n), .sec_strobe(sec_strobe),
        .run_en(run_en), .alarm_en(alarm_en), .period_sel(period_sel),
        .sec_wrap(sec_wrap), .min_wrap(min_wrap), .hour_wrap(hour_wrap),
        .alarm_load(alarm_load), .alarm_secs(alarm_secs),
        .evt_tick(evt_tick), .evt_alarm(evt_alarm)
    );
endmodule

// File: tb/rtc_tick_core_test.sv
module rtc_tick_core_test;
    localparam int P  = 4;
    localparam int SW = 4;
    localparam int MW = 3;
    localparam int HW = 2;
    localparam int CF = 3;
    localparam int CI = 5;
    localparam int AI = 7;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0, run_en = 1'b0, alarm_en = 1'b0;
    logic [1:0] period_sel = 2'd0;
    logic comp_wr_hi = 1'b0, comp_wr_lo = 1'b0;
    logic [7:0] comp_byte = 8'd0;
    logic alarm_load = 1'b0;
    logic [AW-1:0] alarm_secs = '0;
    logic evt_tick, evt_alarm;
    logic [1:0] secs;
    logic [1:0] mins;
    logic [0:0] hours;

    always #2 clk = ~clk;

    rtc_tick_core #(
        .PRESCALE(P), .SEC_WRAP(SW), .MIN_WRAP(MW), .HOUR_WRAP(HW),
        .CORR_FIRST(CF), .CORR_INTERVAL(CI), .ALM_W(AW), .ALM_INIT(AI)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run_en(run_en),
        .alarm_en(alarm_en), .period_sel(period_sel),
        .comp_wr_hi(comp_wr_hi), .comp_wr_lo(comp_wr_lo), .comp_byte(comp_byte),
        .alarm_load(alarm_load), .alarm_secs(alarm_secs),
        .evt_tick(evt_tick), .evt_alarm(evt_alarm),
        .secs(secs), .mins(mins), .hours(hours)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Reference model state
    int m_pre, m_corr, m_s, m_m, m_h, m_alm;
    logic [15:0] m_comp;
    bit e_tick, e_alarm;

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int sec_len(logic [15:0] c);
        int t;
        t = P - int'($signed(c));
        return (t < 1) ? 1 : t;
    endfunction

    function automatic int exp_len(int k, logic [15:0] c);
        if (k == CF + 1 || (k > CF + 1 && ((k - CF - 1) % CI) == 0)) return sec_len(c);
        return P;
    endfunction

    // One clock: update the model at the edge, compare away from it.
    task automatic cyc();
        bit st, sw, mw, hw, ld;
        @(posedge clk);
        if (!rst_n) begin
            m_pre = P; m_corr = CF; m_s = 0; m_m = 0; m_h = 0; m_alm = AI;
            m_comp = 16'd0; e_tick = 0; e_alarm = 0;
        end else begin
            st = tick_en && run_en && (m_pre == 1);
            sw = (m_s == SW - 1);
            mw = sw && (m_m == MW - 1);
            hw = mw && (m_h == HW - 1);
            ld = alarm_load && run_en && alarm_en;
            e_tick = st && (period_sel == 2'd0 || (period_sel == 2'd1 && sw) ||
                            (period_sel == 2'd2 && mw) || (period_sel == 2'd3 && hw));
            e_alarm = st && alarm_en && (m_alm == 1) && !ld;
            if (tick_en && run_en)
                m_pre = (m_pre == 1) ? ((m_corr == 1) ? sec_len(m_comp) : P) : m_pre - 1;
            if (st) begin
                m_corr = (m_corr == 1) ? CI : m_corr - 1;
                m_s = sw ? 0 : m_s + 1;
                if (sw) m_m = mw ? 0 : m_m + 1;
                if (mw) m_h = hw ? 0 : m_h + 1;
            end
            if (ld) m_alm = int'(alarm_secs);
            else if (st && m_alm != 0) m_alm = m_alm - 1;
            if (comp_wr_hi) m_comp[15:8] = comp_byte;
            if (comp_wr_lo) m_comp[7:0] = comp_byte;
        end
        @(negedge clk);
        chk("R2", "secs", int'(secs), m_s);
        chk("R2", "mins", int'(mins), m_m);
        chk("R2", "hours", int'(hours), m_h);
        chk("R3", "evt_tick", int'(evt_tick), int'(e_tick));
        chk("R4", "evt_alarm", int'(evt_alarm), int'(e_alarm));
    endtask

    task automatic do_reset();
        rst_n = 0; tick_en = 0; run_en = 0; alarm_en = 0; period_sel = 0;
        comp_wr_hi = 0; comp_wr_lo = 0; alarm_load = 0;
        repeat (3) cyc();
        rst_n = 1;
    endtask

    task automatic wr_comp(bit hi, logic [7:0] b);
        comp_byte = b; comp_wr_hi = hi; comp_wr_lo = !hi;
        cyc();
        comp_wr_hi = 0; comp_wr_lo = 0;
    endtask

    // Count cycles (enable every cycle) until the seconds field changes.
    task automatic measure(output int n);
        logic [1:0] prev;
        prev = secs; n = 0;
        do begin cyc(); n++; end while (secs == prev && n < 1000);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n, cnt, ts;
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset();
        cyc();
        // R6: reset state
        chk("R6", "secs after reset", int'(secs), 0);
        chk("R6", "evt_tick after reset", int'(evt_tick), 0);
        chk("R6", "evt_alarm after reset", int'(evt_alarm), 0);

        // R1 / R7: second lengths with trim +2
        wr_comp(0, 8'd2);
        run_en = 1; tick_en = 1;
        for (int k = 1; k <= 12; k++) begin
            measure(n);
            if (k == 1) chk("R1", "untrimmed second length", n, P);
            chk("R7", "second length", n, exp_len(k, 16'd2));
        end
        // R1: freeze and resume
        run_en = 0; ts = int'(secs);
        repeat (10) cyc();
        chk("R1", "secs held while stopped", int'(secs), ts);
        run_en = 1;
        measure(n);
        chk("R1", "resume completes second", n, P);

        // R8: clamp of trim larger than prescale
        do_reset();
        wr_comp(0, 8'd10);
        run_en = 1; tick_en = 1;
        for (int k = 1; k <= 5; k++) begin
            measure(n);
            chk("R8", "clamped second length", n, exp_len(k, 16'd10));
        end

        // R9: byte halves written independently
        do_reset();
        wr_comp(0, 8'h02);
        wr_comp(1, 8'hFF);
        run_en = 1; tick_en = 1;
        for (int k = 1; k <= 4; k++) begin
            measure(n);
            if (k == 4) chk("R9", "high byte kept low byte", n, sec_len(16'hFF02));
        end
        wr_comp(0, 8'hFE);
        measure(n);
        for (int k = 5; k <= 9; k++) begin
            if (k > 5) measure(n);
            if (k == 9) chk("R9", "low byte kept high byte", n, sec_len(16'hFFFE));
        end

        // R3: tick counts over one full day for each period select
        for (int p = 0; p < 4; p++) begin
            do_reset();
            period_sel = 2'(p); run_en = 1; tick_en = 1; cnt = 0;
            for (int c = 0; c < SW * MW * HW * P; c++) begin
                cyc();
                if (evt_tick) cnt++;
            end
            chk("R3", "ticks per day", cnt, (p == 0) ? 24 : (p == 1) ? 6 : (p == 2) ? 2 : 1);
        end

        // R10 / R4: alarm and tick on the same boundary
        do_reset();
        period_sel = 0; run_en = 1; tick_en = 1; alarm_en = 1;
        alarm_load = 1; alarm_secs = 8'd3;
        cyc();
        alarm_load = 0;
        n = 0;
        while (!evt_alarm && n < 100) begin cyc(); n++; end
        chk("R4", "alarm at third second", int'(secs), 3);
        chk("R10", "tick with alarm", int'(evt_tick), 1);
        cyc();
        chk("R10", "alarm pulse width", int'(evt_alarm), 0);

        // R5: load ignored while alarm disabled
        do_reset();
        run_en = 1; tick_en = 1; alarm_en = 0;
        alarm_load = 1; alarm_secs = 8'd2;
        cyc();
        alarm_load = 0; alarm_en = 1;
        n = 0;
        while (!evt_alarm && n < 200) begin cyc(); n++; end
        chk("R5", "alarm from reset countdown", int'(mins) * SW + int'(secs), AI);

        // Random phase against the model
        do_reset();
        for (int c = 0; c < 6000; c++) begin
            tick_en = ($urandom % 4) != 0;
            if ($urandom % 64 == 0) run_en = ($urandom % 8) != 0;
            if ($urandom % 50 == 0) alarm_en = $urandom % 2;
            if ($urandom % 300 == 0) period_sel = 2'($urandom % 4);
            alarm_load = ($urandom % 40) == 0;
            alarm_secs = AW'($urandom % 6);
            comp_wr_hi = 0; comp_wr_lo = 0;
            if ($urandom % 150 == 0) begin
                if ($urandom % 2) begin comp_wr_hi = 1; comp_byte = ($urandom % 2) ? 8'hFF : 8'h00; end
                else begin comp_wr_lo = 1; comp_byte = 8'($urandom); end
            end
            cyc();
        end
        alarm_load = 0; comp_wr_hi = 0; comp_wr_lo = 0;

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule